// File: doc/BRIEF.md
# Circular Pre/Post-Event Sample Recorder

This block records a wide sample word into on-chip storage on every qualified clock edge while it is armed. The write address runs round a ring, so the storage keeps overwriting its oldest contents for as long as no event has been seen. When an event marker arrives together with a qualified sample, recording goes on for a programmed number of further samples and then stops. What is left in storage is a window that reaches back from the event by up to the whole depth and forward by the programmed count.

Once recording has stopped, the host unloads the window through a read port that is indexed in time order: index 0 is always the oldest retained sample, whatever address it sits at in the ring. The block also reports whether the ring has wrapped, how many samples are valid, and where the event sample lies in time-ordered terms. Arming again clears all of this state and starts a new recording.

Top module: `trc_window_capture`

## Requirements
- R1: After reset the block is idle: busy_o, done_o and wrapped_o are 0, valid_cnt_o is 0, and no sample is stored until arm_i is pulsed.
- R2: While busy, every cycle with smp_valid_i high stores smp_data_i at the write pointer and advances the pointer by one modulo DEPTH, so address DEPTH-1 is followed by address 0. Cycles with smp_valid_i low store nothing.
- R3: Before the event, recording never stops on its own. Once more than DEPTH samples have been written, the ring holds exactly the most recent DEPTH of them.
- R4: The event is taken only when trig_i is high in the same cycle as a qualified sample during the pre-event phase, and that sample is the event sample. post_cnt_i is sampled in that cycle. Exactly post_cnt_i further qualified samples are then stored, after which done_o is 1, busy_o is 0, and no further sample is written until the next arm.
- R5: With post_cnt_i equal to 0, done_o goes to 1 in the cycle after the event sample, and the event sample is the newest sample in the window.
- R6: wrapped_o goes to 1 on the first write to address DEPTH-1 and stays set until the next arm. valid_cnt_o equals DEPTH when wrapped_o is 1, and otherwise equals the number of samples written since arming.
- R7: A read with rd_en_i high and index rd_idx_i returns the sample stored rd_idx_i positions after the oldest one, on rd_data_o, 1+RD_PIPE clock edges later. The oldest sample is at the stop pointer if the ring has wrapped, and at address 0 if it has not.
- R8: trig_pos_o gives the time-ordered index of the event sample within the stored window, where index 0 is the oldest sample.
- R9: A cycle with arm_i high clears done, wrapped, the write pointer and the post-event count, and enters the pre-event phase. Arming takes priority over a sample or trigger in the same cycle, and that sample is not stored.
- R10: trig_i has no effect while idle, after done, or during the post-event phase, and it has no effect in cycles where smp_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Pulse that clears state and starts recording |
| post_cnt_i | input | ADDR_W | Number of samples to store after the event sample |
| smp_valid_i | input | 1 | Qualifies smp_data_i for this cycle |
| smp_data_i | input | SAMPLE_W | Sample word |
| trig_i | input | 1 | Event marker, taken with a qualified sample |
| busy_o | output | 1 | Recording is in progress |
| done_o | output | 1 | Recording has stopped and the window is ready |
| wrapped_o | output | 1 | The ring has been filled at least once since arming |
| valid_cnt_o | output | ADDR_W+1 | Number of valid samples in the window |
| trig_pos_o | output | ADDR_W | Time-ordered index of the event sample |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | ADDR_W | Time-ordered read index, 0 is the oldest |
| rd_data_o | output | SAMPLE_W | Read data, 1+RD_PIPE edges after the request |

## Verification
The event and the pointer wrap can land on the same edge. The bench provokes this by arming with a zero post-event count and raising the trigger on exactly the DEPTH-th sample, which is written to address DEPTH-1. It then expects done and wrapped to rise together, a full valid count, an event index of DEPTH-1, and oldest-first readback starting at address 0. The bench also puts arm and trigger in the same cycle, and expects the arm to win with nothing recorded.

// File: rtl/trc_pkg.sv
package trc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } trc_state_e;

endpackage

// File: rtl/trc_ctrl.sv
module trc_ctrl
   import trc_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              smp_valid_i,
   input  logic              trig_i,
   input  logic [ADDR_W-1:0] post_cnt_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_ptr_o,
   output logic [ADDR_W-1:0] ev_addr_o,
   output logic              wrapped_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   trc_state_e        state_q;
   logic [ADDR_W-1:0] wr_ptr_q;
   logic [ADDR_W-1:0] left_q;
   logic [ADDR_W-1:0] ev_addr_q;
   logic              wrapped_q;
   logic              capturing;
   logic              ev_hit;

   assign capturing = (state_q == ST_PRE) || (state_q == ST_POST);
   assign wr_en_o   = capturing && smp_valid_i && !arm_i;
   assign ev_hit    = wr_en_o && (state_q == ST_PRE) && trig_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wr_ptr_q  <= '0;
         left_q    <= '0;
         ev_addr_q <= '0;
         wrapped_q <= 1'b0;
      end else if (arm_i) begin
         state_q   <= ST_PRE;
         wr_ptr_q  <= '0;
         left_q    <= '0;
         ev_addr_q <= '0;
         wrapped_q <= 1'b0;
      end else if (wr_en_o) begin
         wr_ptr_q <= wr_ptr_q + 1'b1;
         if (wr_ptr_q == LAST_ADDR) begin
            wrapped_q <= 1'b1;
         end
         if (ev_hit) begin
            ev_addr_q <= wr_ptr_q;
            if (post_cnt_i == '0) begin
               state_q <= ST_DONE;
            end else begin
               state_q <= ST_POST;
               left_q  <= post_cnt_i;
            end
         end else if (state_q == ST_POST) begin
            left_q <= left_q - 1'b1;
            if (left_q == ADDR_W'(1)) begin
               state_q <= ST_DONE;
            end
         end
      end
   end

   assign wr_ptr_o  = wr_ptr_q;
   assign ev_addr_o = ev_addr_q;
   assign wrapped_o = wrapped_q;
   assign busy_o    = capturing;
   assign done_o    = (state_q == ST_DONE);

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> (wr_ptr_q == ADDR_W'($past(wr_ptr_q) + 1'b1)));  // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_o && !arm_i) |=> $stable(wr_ptr_q));  // R2
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> (done_o && $stable(wr_ptr_q)));  // R4
   AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped_q && !arm_i) |=> wrapped_q);  // R6
   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> (state_q == ST_PRE && wr_ptr_q == '0 && !wrapped_q));  // R9
   AST_IDLE_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !arm_i) |=> (state_q == ST_IDLE));  // R10
   AST_POST_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_POST && !arm_i && wr_en_o) |=> (left_q == ADDR_W'($past(left_q) - 1'b1)));  // R10

endmodule

// File: rtl/trc_store.sv
module trc_store #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = $clog2(DEPTH),
   parameter bit RD_PIPE  = 1'b0
) (
   input  logic                clk,
   input  logic                wr_en_i,
   input  logic [ADDR_W-1:0]   wr_addr_i,
   input  logic [SAMPLE_W-1:0] wr_data_i,
   input  logic                rd_en_i,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [SAMPLE_W-1:0] rd_data_o
);

   logic [SAMPLE_W-1:0] ring_q [DEPTH];
   logic [SAMPLE_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         ring_q[wr_addr_i] <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en_i) begin
         rd_q <= ring_q[rd_addr_i];
      end
   end

   generate
      if (RD_PIPE) begin : g_pipe
         logic [SAMPLE_W-1:0] rd_pipe_q;
         always_ff @(posedge clk) begin
            rd_pipe_q <= rd_q;
         end
         assign rd_data_o = rd_pipe_q;
      end else begin : g_direct
         assign rd_data_o = rd_q;
      end
   endgenerate

endmodule

// File: rtl/trc_order.sv
module trc_order #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int CNT_W  = ADDR_W + 1
) (
   input  logic              wrapped_i,
   input  logic [ADDR_W-1:0] stop_ptr_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   input  logic [ADDR_W-1:0] rd_idx_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [ADDR_W-1:0] ev_pos_o,
   output logic [CNT_W-1:0]  valid_cnt_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [ADDR_W-1:0] oldest;

   assign oldest      = wrapped_i ? stop_ptr_i : '0;
   assign rd_addr_o   = oldest + rd_idx_i;
   assign ev_pos_o    = ev_addr_i - oldest;
   assign valid_cnt_o = wrapped_i ? FULL_CNT : {1'b0, stop_ptr_i};

endmodule

// File: rtl/trc_window_capture.sv
module trc_window_capture #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 16,
   parameter bit RD_PIPE  = 1'b0,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int CNT_W   = ADDR_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                arm_i,
   input  logic [ADDR_W-1:0]   post_cnt_i,
   input  logic                smp_valid_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   input  logic                trig_i,
   output logic                busy_o,
   output logic                done_o,
   output logic                wrapped_o,
   output logic [CNT_W-1:0]    valid_cnt_o,
   output logic [ADDR_W-1:0]   trig_pos_o,
   input  logic                rd_en_i,
   input  logic [ADDR_W-1:0]   rd_idx_i,
   output logic [SAMPLE_W-1:0] rd_data_o
);

   initial begin
      assert (DEPTH >= 2 && (1 << ADDR_W) == DEPTH)
         else $error("DEPTH must be a power of two of at least 2");
      assert (SAMPLE_W >= 1)
         else $error("SAMPLE_W must be positive");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_ptr;
   logic [ADDR_W-1:0] ev_addr;
   logic [ADDR_W-1:0] rd_addr;

   trc_ctrl #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .smp_valid_i (smp_valid_i),
      .trig_i      (trig_i),
      .post_cnt_i  (post_cnt_i),
      .wr_en_o     (wr_en),
      .wr_ptr_o    (wr_ptr),
      .ev_addr_o   (ev_addr),
      .wrapped_o   (wrapped_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   trc_order #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) i_order (
      .wrapped_i   (wrapped_o),
      .stop_ptr_i  (wr_ptr),
      .ev_addr_i   (ev_addr),
      .rd_idx_i    (rd_idx_i),
      .rd_addr_o   (rd_addr),
      .ev_pos_o    (trig_pos_o),
      .valid_cnt_o (valid_cnt_o)
   );

   trc_store #(
      .SAMPLE_W (SAMPLE_W),
      .DEPTH    (DEPTH),
      .ADDR_W   (ADDR_W),
      .RD_PIPE  (RD_PIPE)
   ) i_store (
      .clk       (clk),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_ptr),
      .wr_data_i (smp_data_i),
      .rd_en_i   (rd_en_i),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data_o)
   );

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);  // R4
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      valid_cnt_o <= CNT_W'(DEPTH));  // R6
   AST_FULL_WHEN_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrapped_o) |-> (valid_cnt_o == CNT_W'(DEPTH)));  // R6

endmodule

// File: tb/test_trc_window_capture.sv
module test_trc_window_capture;

   localparam int SW    = 16;
   localparam int DEPTH = 16;
   localparam bit PIPE  = 1'b0;
   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = AW + 1;
   localparam int LAT   = 1 + int'(PIPE);

   localparam int NV = 5;
   localparam int V_PRE  [NV] = '{5, 20, 3, 40, 1};
   localparam int V_POST [NV] = '{3, 4, 15, 0, 7};
   localparam int V_GAP  [NV] = '{0, 1, 0, 1, 0};
   localparam int V_TPOS [NV] = '{0, 1, 0, 0, 1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arm_i = 1'b0;
   logic [AW-1:0] post_cnt_i = '0;
   logic          smp_valid_i = 1'b0;
   logic [SW-1:0] smp_data_i = '0;
   logic          trig_i = 1'b0;
   logic          busy_o, done_o, wrapped_o;
   logic [CW-1:0] valid_cnt_o;
   logic [AW-1:0] trig_pos_o;
   logic          rd_en_i = 1'b0;
   logic [AW-1:0] rd_idx_i = '0;
   logic [SW-1:0] rd_data_o;

   int n_run  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   trc_window_capture #(.SAMPLE_W(SW), .DEPTH(DEPTH), .RD_PIPE(PIPE)) i_trc_window_capture (
      .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .post_cnt_i(post_cnt_i),
      .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i),
      .busy_o(busy_o), .done_o(done_o), .wrapped_o(wrapped_o),
      .valid_cnt_o(valid_cnt_o), .trig_pos_o(trig_pos_o),
      .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic do_arm(input int post);
      arm_i = 1'b1;
      post_cnt_i = AW'(post);
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   task automatic put(input int d, input bit t);
      smp_valid_i = 1'b1;
      smp_data_i  = SW'(d);
      trig_i      = t;
      @(negedge clk);
      smp_valid_i = 1'b0;
      trig_i      = 1'b0;
   endtask

   task automatic gap_cycle();
      smp_data_i = 16'hDEAD;
      trig_i     = 1'b1;
      @(negedge clk);
      trig_i     = 1'b0;
   endtask

   task automatic rd(input int idx, output int val);
      rd_en_i  = 1'b1;
      rd_idx_i = AW'(idx);
      @(negedge clk);
      rd_en_i  = 1'b0;
      for (int k = 1; k < LAT; k++) @(negedge clk);
      val = int'(rd_data_o);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "busy", int'(busy_o), 0);
      check("R1", "done", int'(done_o), 0);
      check("R1", "wrapped", int'(wrapped_o), 0);
      check("R1", "valid_cnt", int'(valid_cnt_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 / R1: trigger and samples before any arm are ignored
      put(77, 1'b1);
      put(78, 1'b1);
      check("R10", "busy before arm", int'(busy_o), 0);
      check("R10", "done before arm", int'(done_o), 0);
      check("R1", "valid_cnt before arm", int'(valid_cnt_o), 0);

      // table of vectors: R2 R3 R4 R6 R7 R8 R10
      for (int i = 0; i < NV; i++) begin
         int base, tot, vld, old, tpos;
         base = 1000 * (i + 1);
         do_arm(V_POST[i]);
         check("R9", "busy after arm", int'(busy_o), 1);
         for (int s = 0; s < V_PRE[i]; s++) begin
            put(base + s, s == V_PRE[i] - 1);
            if (V_GAP[i] != 0) gap_cycle();
         end
         for (int s = 0; s < V_POST[i]; s++) begin
            put(base + V_PRE[i] + s, V_TPOS[i] != 0);
            if (V_GAP[i] != 0) gap_cycle();
         end
         for (int s = 0; s < 3; s++) put(base + 900 + s, 1'b1);
         tot  = V_PRE[i] + V_POST[i];
         vld  = (tot >= DEPTH) ? DEPTH : tot;
         old  = tot - vld;
         tpos = (V_PRE[i] - 1) - old;
         check("R4", "done", int'(done_o), 1);
         check("R4", "busy", int'(busy_o), 0);
         check("R6", "wrapped", int'(wrapped_o), (tot >= DEPTH) ? 1 : 0);
         check("R6", "valid_cnt", int'(valid_cnt_o), vld);
         check("R8", "trig_pos", int'(trig_pos_o), tpos);
         for (int k = 0; k < vld; k++) begin
            rd(k, v);
            check("R7", "read oldest-first", v, base + old + k);
         end
      end

      // R5 with R6: event and pointer wrap on the same edge, zero post count
      do_arm(0);
      check("R9", "wrapped cleared by arm", int'(wrapped_o), 0);
      check("R9", "done cleared by arm", int'(done_o), 0);
      for (int s = 0; s < DEPTH; s++) put(7000 + s, s == DEPTH - 1);
      check("R5", "done with post 0", int'(done_o), 1);
      check("R6", "wrapped on last address", int'(wrapped_o), 1);
      check("R6", "valid_cnt full", int'(valid_cnt_o), DEPTH);
      check("R8", "trig_pos last", int'(trig_pos_o), DEPTH - 1);
      rd(0, v);
      check("R7", "oldest at address 0", v, 7000);
      rd(DEPTH - 1, v);
      check("R5", "event sample newest", v, 7000 + DEPTH - 1);

      // R9: arm and trigger in the same cycle; arm wins, sample not stored
      arm_i = 1'b1;
      post_cnt_i = '0;
      smp_valid_i = 1'b1;
      smp_data_i = 16'h0BAD;
      trig_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
      smp_valid_i = 1'b0;
      trig_i = 1'b0;
      check("R9", "busy after arm+trig", int'(busy_o), 1);
      check("R9", "done after arm+trig", int'(done_o), 0);
      check("R9", "valid_cnt after arm+trig", int'(valid_cnt_o), 0);
      put(8100, 1'b0);
      put(8101, 1'b1);
      check("R5", "done after single post-0 event", int'(done_o), 1);
      check("R8", "trig_pos second", int'(trig_pos_o), 1);
      check("R6", "valid_cnt two", int'(valid_cnt_o), 2);
      rd(0, v);
      check("R2", "first stored sample", v, 8100);

      finish_run();
   end

endmodule